// File: doc/BRIEF.md
# Skid-Tolerant Segment Write Buffer

This block sits on the receiving end of a segmented transmit bus. It takes in one bus segment per write cycle, together with that segment's sideband: channel number, start and end markers, error marker and empty-byte count. It stores them in order in a 32-entry FIFO and hands them to a downstream consumer through a first-word-fall-through read port. The block does not interpret packet contents.

Back-pressure goes to the sender through a ready output. Ready drops once eight or fewer FIFO entries remain free. A sender is allowed to finish up to eight more writes after ready falls. Because the threshold always leaves room for that allowance, the FIFO never fills past capacity.

If the sender writes beyond the allowance, the offending segment is not stored. Instead a sticky overflow flag is raised, so the violation is visible until reset. Once ready returns high, the allowance is renewed.

Top module: `swb_top`

## Requirements
- R1: After reset, `ready_o` is 1, `ovf_o` is 0 and `rd_valid_o` is 0.
- R2: Every accepted write is read back in write order, with its data, channel, start, end, error and empty-count fields unchanged.
- R3: `ready_o` is 0 exactly while the FIFO holds DEPTH-SKID (24) or more entries. It changes in the cycle after the write or read that crosses this level.
- R4: While `ready_o` is 0, up to SKID (8) write cycles are accepted and stored, and none of them sets `ovf_o`.
- R5: A write while `ready_o` is 0, after SKID writes have already been accepted since ready fell, is discarded. It sets `ovf_o` from the next cycle.
- R6: Once set, `ovf_o` stays 1 until reset, whatever the later traffic.
- R7: The skid allowance is renewed whenever `ready_o` is 1. After ready rises and falls again, a further SKID writes are accepted without overflow.
- R8: A read request while `rd_valid_o` is 0 has no effect.
- R9: A cycle with both an accepted write and a read leaves the occupancy unchanged, so `ready_o` does not change.
- R10: While `wr_en_i` is 0, the other write inputs are ignored and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write qualifier for the segment and its sideband |
| wr_data_i | input | 128 | Segment data |
| wr_chan_i | input | 8 | Channel number |
| wr_sop_i | input | 1 | Start-of-packet marker |
| wr_eop_i | input | 1 | End-of-packet marker |
| wr_err_i | input | 1 | Packet-error marker |
| wr_mty_i | input | 4 | Count of empty byte lanes |
| ready_o | output | 1 | Sender may write freely |
| ovf_o | output | 1 | Sticky back-pressure violation flag |
| rd_en_i | input | 1 | Pop the head entry when valid |
| rd_valid_o | output | 1 | Head entry present |
| rd_data_o | output | 128 | Head segment data |
| rd_chan_o | output | 8 | Head channel number |
| rd_sop_o | output | 1 | Head start marker |
| rd_eop_o | output | 1 | Head end marker |
| rd_err_o | output | 1 | Head error marker |
| rd_mty_o | output | 4 | Head empty-byte count |

## Verification
A wrong occupancy count shows up at `ready_o` in the very next cycle, because ready moves at the wrong fill level. It also shows up later as a missing or duplicated item when the FIFO is drained. A skid counter that is off by one or is not cleared appears as `ovf_o` rising one write early or late, or not rising at all, in the cycle after the offending write. It then shows up again as an extra or missing entry during the drain. Pointer faults appear immediately as a field mismatch on the first read after the fault.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int unsigned SEG_DATA_W = 128;
  localparam int unsigned SEG_CHAN_W = 8;
  localparam int unsigned SEG_MTY_W  = 4;

  typedef struct packed {
    logic [SEG_DATA_W-1:0] data;
    logic [SEG_CHAN_W-1:0] chan;
    logic                  sop;
    logic                  eop;
    logic                  err;
    logic [SEG_MTY_W-1:0]  mty;
  } seg_t;
endpackage

// File: rtl/swb_store.sv
module swb_store
  import swb_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  seg_t             din_i,
  input  logic             rd_en_i,
  output seg_t             dout_o,
  output logic             valid_o,
  output logic [LVL_W-1:0] level_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             pop;
  seg_t             mem [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign valid_o = (level_q != '0);
  assign pop     = rd_en_i && valid_o;
  assign level_o = level_q;
  assign dout_o  = mem[rd_ptr_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (push_i && (wr_ptr_q == PTR_W'(g))) mem[g] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)    rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({push_i, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  // skid threshold must keep pushes off a full store
  p_no_full_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (level_q < LVL_W'(DEPTH)));

  p_level_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && rd_en_i && valid_o) |=> $stable(level_q));

  p_empty_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !valid_o && !push_i) |=> (level_q == '0));
endmodule

// File: rtl/swb_gate.sv
module swb_gate #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned SKID  = 8,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             ready_o,
  output logic             push_o,
  output logic             ovf_o
);
  localparam int unsigned CNT_W  = $clog2(SKID + 1);
  localparam int unsigned THRESH = DEPTH - SKID;

  logic [CNT_W-1:0] skid_q;
  logic             ovf_q;
  logic             viol;

  assign ready_o = (level_i < LVL_W'(THRESH));
  assign viol    = wr_en_i && !ready_o && (skid_q == CNT_W'(SKID));
  assign push_o  = wr_en_i && !viol;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skid_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (ready_o)     skid_q <= '0;
      else if (push_o) skid_q <= skid_q + 1'b1;
      if (viol) ovf_q <= 1'b1;
    end
  end

  p_skid_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skid_q <= CNT_W'(SKID));

  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);

  p_ovf_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(wr_en_i && !ready_o));

  p_skid_renew_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (skid_q <= CNT_W'(1)));
endmodule

// File: rtl/swb_top.sv
module swb_top
  import swb_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned SKID  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [SEG_DATA_W-1:0] wr_data_i,
  input  logic [SEG_CHAN_W-1:0] wr_chan_i,
  input  logic                  wr_sop_i,
  input  logic                  wr_eop_i,
  input  logic                  wr_err_i,
  input  logic [SEG_MTY_W-1:0]  wr_mty_i,
  output logic                  ready_o,
  output logic                  ovf_o,
  input  logic                  rd_en_i,
  output logic                  rd_valid_o,
  output logic [SEG_DATA_W-1:0] rd_data_o,
  output logic [SEG_CHAN_W-1:0] rd_chan_o,
  output logic                  rd_sop_o,
  output logic                  rd_eop_o,
  output logic                  rd_err_o,
  output logic [SEG_MTY_W-1:0]  rd_mty_o
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  seg_t             wr_seg, rd_seg;
  logic             push;
  logic [LVL_W-1:0] level;

  assign wr_seg = '{data: wr_data_i, chan: wr_chan_i, sop: wr_sop_i,
                    eop: wr_eop_i, err: wr_err_i, mty: wr_mty_i};

  swb_gate #(.DEPTH(DEPTH), .SKID(SKID), .LVL_W(LVL_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .level_i (level),
    .ready_o (ready_o),
    .push_o  (push),
    .ovf_o   (ovf_o)
  );

  swb_store #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (wr_seg),
    .rd_en_i (rd_en_i),
    .dout_o  (rd_seg),
    .valid_o (rd_valid_o),
    .level_o (level)
  );

  assign rd_data_o = rd_seg.data;
  assign rd_chan_o = rd_seg.chan;
  assign rd_sop_o  = rd_seg.sop;
  assign rd_eop_o  = rd_seg.eop;
  assign rd_err_o  = rd_seg.err;
  assign rd_mty_o  = rd_seg.mty;

  p_no_push_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> !push);
endmodule

// File: tb/swb_top_tb_top.sv
module swb_top_tb_top;
  import swb_pkg::*;

  localparam int DEPTH = 32;
  localparam int SKID  = 8;
  localparam int THR   = DEPTH - SKID;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  seg_t wr_s = '0;
  logic ready, ovf, rd_valid;
  logic [SEG_DATA_W-1:0] rd_data;
  logic [SEG_CHAN_W-1:0] rd_chan;
  logic rd_sop, rd_eop, rd_err;
  logic [SEG_MTY_W-1:0] rd_mty;

  int n_chk = 0, n_fail = 0;
  int lvl_m = 0, skid_m = 0;
  seg_t exp_q[$];

  always #5 clk = ~clk;

  swb_top #(.DEPTH(DEPTH), .SKID(SKID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_s.data), .wr_chan_i(wr_s.chan),
    .wr_sop_i(wr_s.sop), .wr_eop_i(wr_s.eop), .wr_err_i(wr_s.err), .wr_mty_i(wr_s.mty),
    .ready_o(ready), .ovf_o(ovf),
    .rd_en_i(rd_en), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_chan_o(rd_chan),
    .rd_sop_o(rd_sop), .rd_eop_o(rd_eop), .rd_err_o(rd_err), .rd_mty_o(rd_mty)
  );

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  function automatic seg_t mk(input int i);
    seg_t s;
    s.data = {4{(32'(i) * 32'h9E37_79B1) ^ 32'hA5A5_0F0F}};
    s.chan = 8'(i * 7 + 3);
    s.sop  = i[0];
    s.eop  = i[1];
    s.err  = i[2];
    s.mty  = 4'(i);
    return s;
  endfunction

  // one clock cycle; entered and left at posedge+1
  task automatic cyc(input bit we, input bit re, input seg_t s);
    bit rdy  = (lvl_m < THR);
    bit viol = we && !rdy && (skid_m == SKID);
    bit push = we && !viol;
    bit pop  = re && (lvl_m > 0);
    wr_en = we; rd_en = re; wr_s = s;
    if (push) exp_q.push_back(s);
    if (rdy) skid_m = 0;
    else if (push) skid_m++;
    lvl_m = lvl_m + int'(push) - int'(pop);
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // scoreboard monitor, R2
  always @(negedge clk) begin
    if (rst_n && rd_en && rd_valid) begin
      seg_t got, exp;
      got = '{data: rd_data, chan: rd_chan, sop: rd_sop, eop: rd_eop, err: rd_err, mty: rd_mty};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", $sformatf("%h", got), "no entry");
      end else begin
        exp = exp_q.pop_front();
        chk(got == exp, "R2", $sformatf("%h", got), $sformatf("%h", exp));
      end
    end
  end

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1
    chk(ready == 1'b1, "R1", $sformatf("%b", ready), "1");
    chk(ovf == 1'b0, "R1", $sformatf("%b", ovf), "0");
    chk(rd_valid == 1'b0, "R1", $sformatf("%b", rd_valid), "0");
    // R8: reads on empty
    cyc(0, 1, '0); cyc(0, 1, '0);
    chk(rd_valid == 1'b0 && ready, "R8", $sformatf("%b%b", rd_valid, ready), "01");
    // R10: idle with junk on the write bus
    for (int i = 0; i < 3; i++) cyc(0, 0, mk(900 + i));
    chk(rd_valid == 1'b0, "R10", $sformatf("%b", rd_valid), "0");
    // R2: order and fields
    for (int i = 0; i < 5; i++) cyc(1, 0, mk(i));
    chk(rd_valid == 1'b1, "R2", $sformatf("%b", rd_valid), "1");
    for (int i = 0; i < 5; i++) cyc(0, 1, '0);
    chk(rd_valid == 1'b0 && exp_q.size() == 0, "R2",
        $sformatf("%b/%0d", rd_valid, exp_q.size()), "0/0");
    // R3: threshold
    base = 10;
    for (int i = 0; i < THR - 1; i++) cyc(1, 0, mk(base + i));
    chk(ready == 1'b1, "R3", $sformatf("%b", ready), "1");
    cyc(1, 0, mk(base + THR));
    chk(ready == 1'b0, "R3", $sformatf("%b", ready), "0");
    // R4: skid writes accepted
    for (int i = 0; i < SKID; i++) begin
      cyc(1, 0, mk(100 + i));
      chk(ovf == 1'b0, "R4", $sformatf("%b", ovf), "0");
    end
    // R7: drop below threshold, rise, fall, full allowance again
    for (int i = 0; i < SKID; i++) cyc(0, 1, '0);
    chk(ready == 1'b0, "R3", $sformatf("%b", ready), "0");
    cyc(0, 1, '0);
    chk(ready == 1'b1, "R3", $sformatf("%b", ready), "1");
    cyc(1, 0, mk(200));
    chk(ready == 1'b0, "R7", $sformatf("%b", ready), "0");
    for (int i = 0; i < SKID; i++) cyc(1, 0, mk(210 + i));
    chk(ovf == 1'b0, "R7", $sformatf("%b", ovf), "0");
    // R5: one write beyond the allowance
    cyc(1, 0, mk(500));
    chk(ovf == 1'b1, "R5", $sformatf("%b", ovf), "1");
    chk(ready == 1'b0, "R5", $sformatf("%b", ready), "0");
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, '0);
    chk(rd_valid == 1'b0 && exp_q.size() == 0, "R5",
        $sformatf("%b/%0d", rd_valid, exp_q.size()), "0/0");
    // R6: sticky
    cyc(1, 0, mk(600)); cyc(1, 0, mk(601)); cyc(0, 1, '0); cyc(0, 1, '0);
    cyc(0, 0, '0);
    chk(ovf == 1'b1, "R6", $sformatf("%b", ovf), "1");
    // R9: simultaneous read and write at the threshold edge
    for (int i = 0; i < THR - 1; i++) cyc(1, 0, mk(700 + i));
    cyc(1, 1, mk(750));
    chk(ready == 1'b1, "R9", $sformatf("%b", ready), "1");
    cyc(1, 0, mk(751));
    chk(ready == 1'b0, "R9", $sformatf("%b", ready), "0");
    for (int i = 0; i < THR; i++) cyc(0, 1, '0);
    chk(rd_valid == 1'b0 && exp_q.size() == 0, "R9",
        $sformatf("%b/%0d", rd_valid, exp_q.size()), "0/0");
    chk(ready == 1'b1 && ovf == 1'b1, "R6", $sformatf("%b%b", ready, ovf), "11");
    finish_sim();
  end
endmodule